// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state a small processor core enters when it executes its sleep instruction, and it brings the core back to full power. A one-cycle sleep strobe with the idle-enable input set puts the core into idle. In idle the CPU is halted, but the clock source chosen before the strobe keeps running, so peripherals keep working. The same strobe with idle-enable clear puts the core into full sleep. Full sleep gates the fast clocks and clears every clock status bit.

A wake can come from an enabled interrupt flag or from a watchdog time-out. Reset is asynchronous and overrides both. The halt drops one cycle after the wake cause appears, and a one-cycle wake pulse reports whether the core should branch to its interrupt vector or continue inline. After a full sleep the primary oscillator restarts. Its stable flag rises only after a start-up count has run out, and the core may execute code before that happens.

Top module: `pm_sequencer`

## Requirements
- R1: A sleep strobe with `idle_en`=1 raises `cpu_halt` on the next cycle. While idle, the clock enables keep the source latched before the strobe, and changes on `clk_sel` have no effect on them.
- R2: Entering idle and remaining in idle leave `stat_pri_stable`, `stat_int_stable` and `stat_sec_run` unchanged.
- R3: A sleep strobe with `idle_en`=0 enters full sleep. In full sleep `clk_en_primary` and `clk_en_intblk` are 0. `clk_en_lfint` follows `wdt_enabled`, and `clk_en_secosc` follows `tmr_osc_en`.
- R4: Entering full sleep clears all three clock status bits on the cycle after the strobe.
- R5: `stat_pri_stable` rises exactly OST_CYCLES (default 1024) clock edges after `clk_en_primary` becomes 1, and never while the primary is gated. After a wake, `cpu_halt` is already 0 before the stable bit rises.
- R6: An interrupt wakes the core only if its flag bit and its enable bit are both 1. On the cycle after such a wake, `cpu_halt` is 0 and `wake_pulse` is 1 for one cycle. Masked flags leave the core halted.
- R7: On an interrupt wake, `wake_vector` is 1 when `gie`=1 and 0 when `gie`=0.
- R8: A watchdog time-out in idle or sleep wakes the core with `wake_vector`=0 and sets the sticky `wdt_wake_flag`. A time-out while running does not set the flag.
- R9: Asserting `rst_n` low immediately returns the block to run. In that state `cpu_halt`, `wake_pulse`, `wdt_wake_flag` and all status bits are 0, and the latched selection is primary. This happens even if a wake cause is present at the same time.
- R10: `clk_sel` codes are 00 primary, 01 secondary timer oscillator, and 10 or 11 internal block. A new code reaches the enables one edge after it is driven. While running, `stat_int_stable` follows the internal-block enable one edge later, and `stat_sec_run` is 1 one edge after code 01 is latched with `tmr_osc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (slow clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_strobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| idle_en | input | 1 | 1 selects idle, 0 selects full sleep |
| clk_sel | input | 2 | Run clock source select |
| irq_flags | input | NUM_IRQ | Interrupt flag bits |
| irq_enables | input | NUM_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_enabled | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| tmr_osc_en | input | 1 | Secondary timer oscillator enable |
| cpu_halt | output | 1 | Halts the CPU |
| clk_en_primary | output | 1 | Primary oscillator enable |
| clk_en_intblk | output | 1 | Internal oscillator block enable |
| clk_en_lfint | output | 1 | Low-frequency internal oscillator enable |
| clk_en_secosc | output | 1 | Secondary timer oscillator enable |
| stat_pri_stable | output | 1 | Primary clock stable status |
| stat_int_stable | output | 1 | Internal block stable status |
| stat_sec_run | output | 1 | Running from secondary oscillator status |
| wake_pulse | output | 1 | One-cycle pulse on wake |
| wake_vector | output | 1 | With wake_pulse: 1 vector, 0 continue |
| wdt_wake_flag | output | 1 | Sticky watchdog-wake status |

## Verification
The hardest case to reach from the ports is the idle hold of a stable flag while the clock select input changes. The primary must first finish its full start-up count, then idle is entered, and `clk_sel` is moved while the core is halted. The bench waits out the full start-up count after reset, checking one edge before and at the expiry. It then enters idle and toggles the select, and checks that neither the status bits nor the enables move. A vector table covers wake causes that are masked, enabled, gated by `gie` and watchdog-driven, in both idle and sleep.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_SLEEP = 2'd2
   } pm_state_e;

   localparam logic [1:0] SEL_PRI = 2'b00;
   localparam logic [1:0] SEL_SEC = 2'b01;
endpackage

// File: rtl/pm_fsm.sv
module pm_fsm
   import pm_pkg::*;
#(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_strobe,
   input  logic               idle_en,
   input  logic [NUM_IRQ-1:0] irq_flags,
   input  logic [NUM_IRQ-1:0] irq_enables,
   input  logic               gie,
   input  logic               wdt_timeout,
   output pm_state_e          state,
   output logic               enter_sleep,
   output logic               enter_idle,
   output logic               wake_pulse,
   output logic               wake_vector,
   output logic               wdt_flag
);
   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("pm_fsm: NUM_IRQ must be at least 1");
      end
   endgenerate

   logic [NUM_IRQ-1:0] armed;
   genvar g;
   generate
      for (g = 0; g < NUM_IRQ; g++) begin : g_arm
         assign armed[g] = irq_flags[g] & irq_enables[g];
      end
   endgenerate

   logic irq_wake, low_power, wake_any;
   pm_state_e state_nx;

   assign irq_wake    = |armed;
   assign low_power   = (state != PM_RUN);
   assign wake_any    = irq_wake | wdt_timeout;
   assign enter_sleep = (state == PM_RUN) && sleep_strobe && !idle_en;
   assign enter_idle  = (state == PM_RUN) && sleep_strobe && idle_en;

   always_comb begin
      state_nx = state;
      if (enter_sleep)             state_nx = PM_SLEEP;
      else if (enter_idle)         state_nx = PM_IDLE;
      else if (low_power && wake_any) state_nx = PM_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= PM_RUN;
         wake_pulse  <= 1'b0;
         wake_vector <= 1'b0;
         wdt_flag    <= 1'b0;
      end else begin
         state       <= state_nx;
         wake_pulse  <= low_power && wake_any;
         wake_vector <= low_power && irq_wake && gie;
         wdt_flag    <= wdt_flag | (low_power && wdt_timeout);
      end
   end

   AST_HALT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PM_RUN) && sleep_strobe) |=> (state != PM_RUN)); // R1
   AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && !irq_wake && !wdt_timeout) |=> (state != PM_RUN) && !wake_pulse); // R6
   AST_NO_VEC_NO_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && !gie) |=> !wake_vector); // R7
   AST_WDT_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && wdt_timeout && !irq_wake) |=> wake_pulse && !wake_vector && wdt_flag); // R8
endmodule

// File: rtl/pm_clkgate.sv
module pm_clkgate
   import pm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pm_state_e  state,
   input  logic       sleep_strobe,
   input  logic [1:0] clk_sel,
   input  logic       wdt_enabled,
   input  logic       tmr_osc_en,
   output logic [1:0] sel_q,
   output logic       en_pri,
   output logic       en_int,
   output logic       en_lf,
   output logic       en_sec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sel_q <= SEL_PRI;
      else if ((state == PM_RUN) && !sleep_strobe) sel_q <= clk_sel;
   end

   logic gated;
   assign gated  = (state == PM_SLEEP);
   assign en_pri = !gated && (sel_q == SEL_PRI);
   assign en_int = !gated && sel_q[1];
   assign en_lf  = wdt_enabled;
   assign en_sec = tmr_osc_en;

   AST_IDLE_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PM_RUN) |=> $stable(sel_q)); // R1
endmodule

// File: rtl/pm_status.sv
module pm_status
   import pm_pkg::*;
#(
   parameter int OST_CYCLES = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pm_state_e  state,
   input  logic       enter_sleep,
   input  logic       enter_idle,
   input  logic       en_pri,
   input  logic       en_int,
   input  logic [1:0] sel_q,
   input  logic       tmr_osc_en,
   output logic       pri_ok,
   output logic       int_ok,
   output logic       sec_run
);
   localparam int CNT_W = (OST_CYCLES > 2) ? $clog2(OST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OST_CYCLES - 1);

   generate
      if (OST_CYCLES < 2) begin : g_bad_ost
         $error("pm_status: OST_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] ost_cnt;
   logic             updating;
   assign updating = (state == PM_RUN) && !enter_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_ok  <= 1'b0;
         int_ok  <= 1'b0;
         sec_run <= 1'b0;
         ost_cnt <= '0;
      end else if (enter_sleep) begin
         pri_ok  <= 1'b0;
         int_ok  <= 1'b0;
         sec_run <= 1'b0;
         ost_cnt <= '0;
      end else if (updating) begin
         if (!en_pri) begin
            pri_ok  <= 1'b0;
            ost_cnt <= '0;
         end else if (!pri_ok) begin
            if (ost_cnt == CNT_LAST) begin
               pri_ok  <= 1'b1;
               ost_cnt <= '0;
            end else begin
               ost_cnt <= ost_cnt + 1'b1;
            end
         end
         int_ok  <= en_int;
         sec_run <= (sel_q == SEL_SEC) && tmr_osc_en;
      end
   end

   AST_IDLE_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_idle || state == PM_IDLE) |=> $stable({pri_ok, int_ok, sec_run})); // R2
   AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      enter_sleep |=> !pri_ok && !int_ok && !sec_run); // R4
   AST_PRI_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && !en_pri) |=> !pri_ok); // R5
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
   import pm_pkg::*;
#(
   parameter int NUM_IRQ    = 4,
   parameter int OST_CYCLES = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_strobe,
   input  logic               idle_en,
   input  logic [1:0]         clk_sel,
   input  logic [NUM_IRQ-1:0] irq_flags,
   input  logic [NUM_IRQ-1:0] irq_enables,
   input  logic               gie,
   input  logic               wdt_enabled,
   input  logic               wdt_timeout,
   input  logic               tmr_osc_en,
   output logic               cpu_halt,
   output logic               clk_en_primary,
   output logic               clk_en_intblk,
   output logic               clk_en_lfint,
   output logic               clk_en_secosc,
   output logic               stat_pri_stable,
   output logic               stat_int_stable,
   output logic               stat_sec_run,
   output logic               wake_pulse,
   output logic               wake_vector,
   output logic               wdt_wake_flag
);
   pm_state_e  state;
   logic       enter_sleep, enter_idle;
   logic [1:0] sel_q;

   pm_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .idle_en(idle_en),
      .irq_flags(irq_flags), .irq_enables(irq_enables), .gie(gie),
      .wdt_timeout(wdt_timeout), .state(state), .enter_sleep(enter_sleep),
      .enter_idle(enter_idle), .wake_pulse(wake_pulse), .wake_vector(wake_vector),
      .wdt_flag(wdt_wake_flag)
   );

   pm_clkgate u_gate (
      .clk(clk), .rst_n(rst_n), .state(state), .sleep_strobe(sleep_strobe),
      .clk_sel(clk_sel), .wdt_enabled(wdt_enabled), .tmr_osc_en(tmr_osc_en),
      .sel_q(sel_q), .en_pri(clk_en_primary), .en_int(clk_en_intblk),
      .en_lf(clk_en_lfint), .en_sec(clk_en_secosc)
   );

   pm_status #(.OST_CYCLES(OST_CYCLES)) u_stat (
      .clk(clk), .rst_n(rst_n), .state(state), .enter_sleep(enter_sleep),
      .enter_idle(enter_idle), .en_pri(clk_en_primary), .en_int(clk_en_intblk),
      .sel_q(sel_q), .tmr_osc_en(tmr_osc_en), .pri_ok(stat_pri_stable),
      .int_ok(stat_int_stable), .sec_run(stat_sec_run)
   );

   assign cpu_halt = (state != PM_RUN);

   AST_SLEEP_GATES_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SLEEP) |-> !clk_en_primary && !clk_en_intblk); // R3
   AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> !cpu_halt); // R6
endmodule

// File: tb/sim_pm_sequencer.sv
module sim_pm_sequencer;
   localparam int NI  = 4;
   localparam int OST = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_strobe = 0, idle_en = 0, gie = 0, wdt_enabled = 0, wdt_timeout = 0, tmr_osc_en = 0;
   logic [1:0] clk_sel = 2'b00;
   logic [NI-1:0] irq_flags = '0, irq_enables = '0;
   logic cpu_halt, clk_en_primary, clk_en_intblk, clk_en_lfint, clk_en_secosc;
   logic stat_pri_stable, stat_int_stable, stat_sec_run, wake_pulse, wake_vector, wdt_wake_flag;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pm_sequencer #(.NUM_IRQ(NI), .OST_CYCLES(OST)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .idle_en(idle_en),
      .clk_sel(clk_sel), .irq_flags(irq_flags), .irq_enables(irq_enables), .gie(gie),
      .wdt_enabled(wdt_enabled), .wdt_timeout(wdt_timeout), .tmr_osc_en(tmr_osc_en),
      .cpu_halt(cpu_halt), .clk_en_primary(clk_en_primary), .clk_en_intblk(clk_en_intblk),
      .clk_en_lfint(clk_en_lfint), .clk_en_secosc(clk_en_secosc),
      .stat_pri_stable(stat_pri_stable), .stat_int_stable(stat_int_stable),
      .stat_sec_run(stat_sec_run), .wake_pulse(wake_pulse), .wake_vector(wake_vector),
      .wdt_wake_flag(wdt_wake_flag)
   );

   // row: {idle, flags[4], enables[4], gie, wdt, exp_wake, exp_vector}
   localparam logic [12:0] VEC [8] = '{
      13'b1_0001_0001_1_0_1_1,
      13'b0_0010_0010_0_0_1_0,
      13'b1_0100_0000_1_0_0_0,
      13'b0_1000_0111_1_0_0_0,
      13'b0_0000_0000_1_1_1_0,
      13'b1_1000_1000_1_0_1_1,
      13'b0_0101_0100_1_0_1_1,
      13'b1_0011_0001_0_1_1_0
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wake_by_irq();
      irq_flags = 4'b0001; irq_enables = 4'b0001;
      tick();
      irq_flags = '0; irq_enables = '0;
      tick();
   endtask

   task automatic enter(input logic idle);
      idle_en = idle; sleep_strobe = 1;
      tick();
      sleep_strobe = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R9: reset state
      chk("R9 halt", cpu_halt, 1'b0);
      chk("R9 wake", wake_pulse, 1'b0);
      chk("R9 flag", wdt_wake_flag, 1'b0);
      chk("R9 pri_stable", stat_pri_stable, 1'b0);
      chk("R10 pri enable at reset", clk_en_primary, 1'b1);
      chk("R10 int enable at reset", clk_en_intblk, 1'b0);
      rst_n = 1;
      // R5: stable after exactly OST edges
      repeat (OST - 1) tick();
      chk("R5 not yet stable", stat_pri_stable, 1'b0);
      tick();
      chk("R5 stable at count", stat_pri_stable, 1'b1);

      // R8: watchdog in run does not set flag
      wdt_timeout = 1; tick(); wdt_timeout = 0;
      chk("R8 run wdt no flag", wdt_wake_flag, 1'b0);
      chk("R8 run wdt no halt", cpu_halt, 1'b0);

      // R1 R2: idle holds clocks and status while select changes
      enter(1'b1);
      chk("R1 idle halt", cpu_halt, 1'b1);
      chk("R2 idle keeps pri_stable", stat_pri_stable, 1'b1);
      clk_sel = 2'b10;
      tick(); tick();
      chk("R1 idle pri enable held", clk_en_primary, 1'b1);
      chk("R1 idle int enable held", clk_en_intblk, 1'b0);
      chk("R2 idle still stable", stat_pri_stable, 1'b1);
      chk("R2 idle int status held", stat_int_stable, 1'b0);
      clk_sel = 2'b00;
      wake_by_irq();
      chk("R6 awake", cpu_halt, 1'b0);

      // R6 R7 R8: vector table
      for (int i = 0; i < 8; i++) begin
         enter(VEC[i][12]);
         chk("R1 halt on entry", cpu_halt, 1'b1);
         irq_flags = VEC[i][11:8]; irq_enables = VEC[i][7:4];
         gie = VEC[i][3]; wdt_timeout = VEC[i][2];
         tick();
         chk("R6 wake pulse", wake_pulse, VEC[i][1]);
         chk("R7 vector", wake_vector, VEC[i][0]);
         chk("R6 halt after cause", cpu_halt, ~VEC[i][1]);
         irq_flags = '0; irq_enables = '0; gie = 0; wdt_timeout = 0;
         if (!VEC[i][1]) wake_by_irq();
         else tick();
      end
      chk("R8 sticky flag", wdt_wake_flag, 1'b1);

      // R3 R4: full sleep gating and clearing
      rst_n = 0; tick(); rst_n = 1;
      repeat (OST + 2) tick();
      chk("R5 stable again", stat_pri_stable, 1'b1);
      wdt_enabled = 1; tmr_osc_en = 1;
      enter(1'b0);
      chk("R3 pri gated", clk_en_primary, 1'b0);
      chk("R3 int gated", clk_en_intblk, 1'b0);
      chk("R3 lf follows wdt", clk_en_lfint, 1'b1);
      chk("R3 sec follows enable", clk_en_secosc, 1'b1);
      chk("R4 pri status cleared", stat_pri_stable, 1'b0);
      wdt_enabled = 0; #1;
      chk("R3 lf off without wdt", clk_en_lfint, 1'b0);
      irq_flags = 4'b0100; irq_enables = 4'b0100; gie = 1;
      tick();
      irq_flags = '0; irq_enables = '0; gie = 0;
      chk("R5 running before stable", cpu_halt, 1'b0);
      chk("R5 pri enabled on wake", clk_en_primary, 1'b1);
      chk("R5 not stable on wake", stat_pri_stable, 1'b0);
      repeat (OST - 1) tick();
      chk("R5 one edge short", stat_pri_stable, 1'b0);
      tick();
      chk("R5 stable after wake", stat_pri_stable, 1'b1);

      // R10: select codes and run status
      clk_sel = 2'b10; tick();
      chk("R10 int enabled", clk_en_intblk, 1'b1);
      chk("R10 pri off", clk_en_primary, 1'b0);
      tick();
      chk("R10 int stable", stat_int_stable, 1'b1);
      clk_sel = 2'b01; tick(); tick();
      chk("R10 sec run", stat_sec_run, 1'b1);
      chk("R10 int status off", stat_int_stable, 1'b0);
      // R2: idle entry on the sec source keeps status
      enter(1'b1);
      chk("R2 sec run held", stat_sec_run, 1'b1);
      // R9: reset with wake cause present
      wdt_timeout = 1; irq_flags = 4'b1111; irq_enables = 4'b1111;
      rst_n = 0; #1;
      chk("R9 halt cleared", cpu_halt, 1'b0);
      chk("R9 status cleared", stat_sec_run, 1'b0);
      tick();
      chk("R9 no wake under reset", wake_pulse, 1'b0);
      chk("R9 flag under reset", wdt_wake_flag, 1'b0);
      wdt_timeout = 0; irq_flags = '0; irq_enables = '0;
      rst_n = 1; tick();

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule